// File: doc/BRIEF.md
# Programmable Periodic Tick Timer

This block is a down-counting interval timer for an always-on timekeeping domain. Each decrement is paced by a 32768 Hz time base. The block makes that base itself from the system clock with a prescaler that divides by `PRESC_DIV`. Software programs a 16-bit reload value in two byte writes. It then sets the run bit in a control byte. The block raises an event flag every time the count expires. The event flag, gated by an interrupt enable, drives the `irq` output.

Two modes are available: periodic, where the counter reloads itself, and single-shot, where the counter stops and drops its run bit. To get an event rate of 2^k Hz, software loads a reload value of 0x8000 shifted right by k. Any write to a dedicated address zeroes the prescaler. This lets software line up the first expiry with its own write. A busy bit at the top of the control byte belongs to a companion function that this block does not have. It always reads 0.

Register access is a simple byte bus: `addr`, `wr_en` and `wr_data` for writes, and a combinational `rd_data` for the selected address. Unmapped addresses read 0.

Top module: `tick_timer`

## Requirements
- R1: After reset the control byte (address 0x10), both reload bytes (0x12, 0x13) and `irq` read 0.
- R2: The control byte at 0x10 holds run in bit 3, interrupt enable in bit 2, event flag in bit 1 and periodic mode in bit 0. The reload value's low byte is at 0x12 and its high byte at 0x13, and both read back what was written.
- R3: The count steps once every `PRESC_DIV` clock cycles. Any write to 0x20 zeroes the prescaler and suppresses that cycle's step. The first expiry is therefore exactly reload × `PRESC_DIV` cycles after the write edge to 0x20.
- R4: In periodic mode (bit 0 = 1) the counter reloads when it expires and keeps running. Successive expiries are reload × `PRESC_DIV` cycles apart.
- R5: In single-shot mode (bit 0 = 0) one expiry sets the flag and clears run (bit 3). No further expiry follows.
- R6: Each expiry sets the flag. Writing 1 to bit 1 of the control byte clears it, and writing 0 there leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R7: `irq` is high exactly while both the flag and the interrupt enable are set.
- R8: A reload value of 0 counts as 65536 steps.
- R9: Bit 7 of the control byte is a read-only busy indicator that reads 0. Writes to it have no effect.
- R10: A reload value of 0x8000 >> k gives 2^k expiries per 32768 prescaler steps, for k from 0 to 15.
- R11: A reload write while the timer runs does not change the count in progress. It takes effect at the next reload.
- R12: Setting run from 0 to 1 loads the counter from the reload value. Clearing run freezes the count, and no expiry occurs while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address for reads and writes |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request: flag AND interrupt enable |

## Verification
On every cycle the assertions check the following:
- an expiry always leaves the flag set, even against a clearing write;
- a single-shot expiry always drops run;
- a periodic expiry reloads the counter from the value held the cycle before;
- the count only moves on a load or on a prescaler step while running, stays within 1..65536 while running, and never exceeds 65536;
- any rise of `irq` traces back to an expiry or a control write;
- the busy bit reads 0.

Only the bench scenarios can show the exact distance from a prescaler clear to the first expiry, the period sweep over k, the 65536-step period of a zero reload, and the deferred effect of a reload write on a running count.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int RLD_W  = 16;
  localparam int CNT_W  = RLD_W + 1;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_RLD_LO = 8'h12;
  localparam logic [ADDR_W-1:0] ADR_RLD_HI = 8'h13;
  localparam logic [ADDR_W-1:0] ADR_PCLR   = 8'h20;

  localparam int BIT_BUSY = 7;
  localparam int BIT_RUN  = 3;
  localparam int BIT_IEN  = 2;
  localparam int BIT_FLAG = 1;
  localparam int BIT_RPT  = 0;

  // Number of prescaler steps that one reload value stands for.
  function automatic logic [CNT_W-1:0] reload_span(input logic [RLD_W-1:0] r);
    if (r == '0) reload_span = {1'b1, {RLD_W{1'b0}}};
    else         reload_span = {1'b0, r};
  endfunction

  // Reload value for an event rate of 2^k Hz on a 32768 Hz base.
  function automatic logic [RLD_W-1:0] rate_reload(input int unsigned k);
    rate_reload = 16'h8000 >> k;
  endfunction

  // Next counter value for one prescaler step.
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                   input logic rpt,
                                                   input logic [RLD_W-1:0] r);
    if (c == CNT_W'(1)) step_count = rpt ? reload_span(r) : '0;
    else                step_count = c - CNT_W'(1);
  endfunction

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PW = $clog2(DIV) + 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] presc;

  assign tick = !clr && (presc == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               presc <= '0;
    else if (clr)             presc <= '0;
    else if (presc == LAST)   presc <= '0;
    else                      presc <= presc + PW'(1);
  end
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tick_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              expire,
  output logic              run,
  output logic              ien,
  output logic              flag,
  output logic              rpt,
  output logic [RLD_W-1:0]  reload,
  output logic              ctrl_wr,
  output logic              load
);
  logic lo_wr, hi_wr;

  assign ctrl_wr = wr_en && (addr == ADR_CTRL);
  assign lo_wr   = wr_en && (addr == ADR_RLD_LO);
  assign hi_wr   = wr_en && (addr == ADR_RLD_HI);
  assign load    = ctrl_wr && wr_data[BIT_RUN] && !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      ien <= 1'b0;
      rpt <= 1'b0;
    end else begin
      if (expire && !rpt) run <= 1'b0;
      else if (ctrl_wr)   run <= wr_data[BIT_RUN];
      if (ctrl_wr) begin
        ien <= wr_data[BIT_IEN];
        rpt <= wr_data[BIT_RPT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            flag <= 1'b0;
    else if (expire)                       flag <= 1'b1;
    else if (ctrl_wr && wr_data[BIT_FLAG]) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '0;
    end else begin
      if (lo_wr) reload[7:0]  <= wr_data;
      if (hi_wr) reload[15:8] <= wr_data;
    end
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic             rpt,
  input  logic [RLD_W-1:0] reload,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);
  assign expire = run && tick && !load && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= reload_span(reload);
    else if (run && tick) cnt <= step_count(cnt, rpt, reload);
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int PRESC_DIV = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic             tick, expire, load, ctrl_wr, pclr_wr;
  logic             run, ien, flag, rpt;
  logic             busy;
  logic [RLD_W-1:0] reload;
  logic [CNT_W-1:0] cnt;

  assign pclr_wr = wr_en && (addr == ADR_PCLR);
  assign busy    = 1'b0;

  tt_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(pclr_wr), .tick(tick)
  );

  tt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .expire(expire), .run(run), .ien(ien), .flag(flag), .rpt(rpt),
    .reload(reload), .ctrl_wr(ctrl_wr), .load(load)
  );

  tt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .load(load),
    .rpt(rpt), .reload(reload), .expire(expire), .cnt(cnt)
  );

  always_comb begin
    rd_data = '0;
    case (addr)
      ADR_CTRL: begin
        rd_data[BIT_BUSY] = busy;
        rd_data[BIT_RUN]  = run;
        rd_data[BIT_IEN]  = ien;
        rd_data[BIT_FLAG] = flag;
        rd_data[BIT_RPT]  = rpt;
      end
      ADR_RLD_LO: rd_data = reload[7:0];
      ADR_RLD_HI: rd_data = reload[15:8];
      default:    rd_data = '0;
    endcase
  end

  assign irq = flag && ien;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic              ctrl_wr,
  input logic              expire,
  input logic              load,
  input logic              tick,
  input logic              run,
  input logic              ien,
  input logic              flag,
  input logic              rpt,
  input logic [CNT_W-1:0]  cnt,
  input logic [RLD_W-1:0]  reload
);
  AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag); // R6

  AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !rpt |=> !run); // R5

  AST_PERIODIC_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    expire && rpt && !ctrl_wr |=> run && (cnt == reload_span($past(reload)))); // R4

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(expire) || $past(ctrl_wr))); // R7

  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !(run && tick) |=> $stable(cnt)); // R12

  AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt != '0)); // R8

  AST_COUNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= {1'b1, {RLD_W{1'b0}}}); // R8

  AST_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADR_CTRL) |-> !rd_data[BIT_BUSY]); // R9
endmodule

bind tick_timer tick_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_data(rd_data), .irq(irq),
  .ctrl_wr(ctrl_wr), .expire(expire), .load(load), .tick(tick),
  .run(run), .ien(ien), .flag(flag), .rpt(rpt), .cnt(cnt), .reload(reload)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  localparam int DIV = 2;
  localparam logic [7:0] CTRL_A = 8'h10;
  localparam logic [7:0] LO_A   = 8'h12;
  localparam logic [7:0] HI_A   = 8'h13;
  localparam logic [7:0] PCLR_A = 8'h20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = CTRL_A;
  logic [7:0] wr_data = 8'h00;
  wire  [7:0] rd_data;
  wire        irq;

  int nvec = 0, nbad = 0, ecount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) ecount <= ecount + 1;

  tick_timer #(.PRESC_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called in the low phase; the write lands on the next rising edge.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; addr = CTRL_A;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #0.5;
    d = rd_data;
    addr = CTRL_A;
    #0.5;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_flag(input int lim, output int t);
    t = -1;
    for (int i = 0; i < lim; i++) begin
      if (rd_data[1] === 1'b1) begin
        t = ecount;
        break;
      end
      @(negedge clk);
      #1;
    end
  endtask

  task automatic arm(input int r, input logic [7:0] c, output int t0);
    wr(CTRL_A, 8'h02);
    wr(LO_A, r[7:0]);
    wr(HI_A, r[15:8]);
    wr(CTRL_A, c);
    wr(PCLR_A, 8'h00);
    t0 = ecount;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", ecount);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int t0, t1, t2, r;

    // R1: reset values
    idle(3);
    rd(CTRL_A, d); chk("R1 ctrl after reset", d, 0);
    rd(LO_A, d);   chk("R1 reload low after reset", d, 0);
    rd(HI_A, d);   chk("R1 reload high after reset", d, 0);
    chk("R1 irq after reset", irq, 0);
    @(negedge clk); rst_n = 1'b1; #1;

    // R2: register map readback
    wr(LO_A, 8'hA5);
    wr(HI_A, 8'h3C);
    rd(LO_A, d); chk("R2 reload low readback", d, 8'hA5);
    rd(HI_A, d); chk("R2 reload high readback", d, 8'h3C);
    wr(CTRL_A, 8'h05);
    rd(CTRL_A, d); chk("R2 ctrl ien+periodic readback", d, 8'h05);
    wr(CTRL_A, 8'h00);

    // R9: busy bit read-only
    wr(CTRL_A, 8'h84);
    rd(CTRL_A, d); chk("R9 busy ignores write", d, 8'h04);
    wr(CTRL_A, 8'h00);

    // R3: first expiry after prescaler clear
    arm(6, 8'h09, t0);
    wait_flag(100, t1);
    chk("R3 first expiry distance", t1 - t0, 6 * DIV);

    // R3: a second clear mid-step restarts the step phase
    arm(4, 8'h09, t0);
    idle(1);
    wr(PCLR_A, 8'h00);
    t0 = ecount;
    wait_flag(100, t1);
    chk("R3 clear suppresses step", t1 - t0, 4 * DIV);

    // R4 / R10: rate sweep over 2^k Hz
    for (int k = 4; k <= 15; k++) begin
      r = 32768 / (1 << k);
      arm(r, 8'h0D, t0);
      wait_flag(r * DIV + 20, t1);
      chk($sformatf("R10 first period k=%0d", k), t1 - t0, r * DIV);
      wr(CTRL_A, 8'h0F);
      chk($sformatf("R6 flag cleared k=%0d", k), rd_data[1], 0);
      wait_flag(r * DIV + 20, t2);
      chk($sformatf("R4 periodic interval k=%0d", k), t2 - t1, r * DIV);
      chk($sformatf("R4 run kept k=%0d", k), rd_data[3], 1);
    end

    // R5: single-shot
    arm(5, 8'h08, t0);
    wait_flag(100, t1);
    chk("R5 single-shot expiry distance", t1 - t0, 5 * DIV);
    chk("R5 run cleared, flag set", rd_data, 8'h02);
    wr(CTRL_A, 8'h02);
    idle(40);
    chk("R5 no further expiry", rd_data, 8'h00);

    // R7 / R6: interrupt gating, write 0 keeps flag
    arm(3, 8'h09, t0);
    wait_flag(100, t1);
    chk("R7 irq low with enable off", irq, 0);
    wr(CTRL_A, 8'h0D);
    chk("R7 irq high with flag and enable", irq, 1);
    chk("R6 writing 0 keeps flag", rd_data[1], 1);
    wr(CTRL_A, 8'h0F);
    chk("R7 irq low after flag clear", irq, 0);
    wr(CTRL_A, 8'h02);

    // R12: stop freezes, restart reloads fully
    arm(10, 8'h09, t0);
    idle(5);
    wr(CTRL_A, 8'h02);
    idle(60);
    chk("R12 no expiry while stopped", rd_data[1], 0);
    wr(CTRL_A, 8'h09);
    wr(PCLR_A, 8'h00);
    t0 = ecount;
    wait_flag(100, t1);
    chk("R12 restart loads full reload", t1 - t0, 10 * DIV);

    // R11: reload write while running is deferred
    arm(3, 8'h0D, t0);
    wr(LO_A, 8'd6);
    wait_flag(100, t1);
    chk("R11 current count unaffected", t1 - t0, 3 * DIV);
    wr(CTRL_A, 8'h0F);
    wait_flag(100, t2);
    chk("R11 new reload at next period", t2 - t1, 6 * DIV);

    // R8: zero reload means 65536 steps
    arm(0, 8'h0D, t0);
    wait_flag(65536 * DIV + 50, t1);
    chk("R8 zero reload period", t1 - t0, 65536 * DIV);
    wr(CTRL_A, 8'h02);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule